// File: doc/BRIEF.md
# Straight-Fill Microprogram Control Store Loader

This block manages a small on-chip store of microcode held in fixed-size blocks, each large enough for one module of a microprogram. A loader on the memory side streams a microprogram in, one module per beat. The low bits of the program's memory start address select a residence entry. That entry maps to a base block, moved forward by a per-entry failure offset. The first module lands in that block, flagged as a program start, and later modules fill the blocks that follow. Every block keeps the memory address of the module it holds as a tag.

The sequencer side sends one request per cycle and receives a registered answer in the next cycle. There are three request types. A start lookup resolves a program's start address through its residence entry. A step lookup moves from the current block to the next one. A jump lookup searches all block tags for a module address. Each answer is exactly one of hit (with block index, end-op flag and module payload), miss (the module must be fetched from main memory), or done (the current block held the end-op).

When a program does not fit, the rest of its modules are dropped and the entry's failure offset grows, so that the next load of the program begins further along. A build-time option lets loading and stepping wrap from the last block back to block 0.

Top module: `ucs_straight_loader`

## Requirements
- R1: A program's residence entry is `ld_addr[ENT_W-1:0]`. Its start block is `(entry * NUM_BLK/NUM_ENT + fail_offset[entry]) mod NUM_BLK`. With the defaults, entry e starts at block 2e while its offset is 0.
- R2: A beat with `ld_first`=1 writes its module into the start block with the start flag set. Each following beat of the same program writes the next block up, with the start flag clear. Every written block is tagged with the beat's `ld_addr` and flagged end-op when `ld_last`=1.
- R3: When wrap is off, no block past `NUM_BLK-1` is written. Beats that arrive after the last block has been filled are dropped. Loading of a program ends at its `ld_last` beat.
- R4: A start lookup (`rq_kind`=0) hits only if the entry for `rq_addr` has been loaded, the block it points to has its start flag set, and that block's tag equals `rq_addr`. Otherwise it misses, which includes the case where a later load has overwritten that block.
- R5: A step lookup (`rq_kind`=1) from block b, where b holds no end-op, hits block b+1 if that block is loaded and is not a program start. It misses if b+1 is a program start, is empty, or (when wrap is off) lies past the last block.
- R6: A step lookup from a block flagged end-op answers done.
- R7: A jump lookup (`rq_kind`=2) compares `rq_addr` with every loaded block's tag. It hits the lowest-indexed matching block and misses if no block matches.
- R8: Every failure offset is 0 after reset. The first dropped beat of a load adds `FAIL_INC` (default 2) to that program's entry, saturating at the counter's maximum.
- R9: With `WRAP_EN`=1, loading continues from the last block to block 0 until `NUM_BLK` blocks have been written, and a step from the last block goes on to block 0.
- R10: Each request is answered exactly one cycle later with exactly one of `rs_hit`, `rs_miss`, `rs_done`. `rs_blk`, `rs_last` and `rs_data` are zero unless the answer is a hit.
- R11: After reset, no block and no residence entry holds a program, and no answer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load beat present |
| ld_first | input | 1 | Beat carries the first module of a program |
| ld_last | input | 1 | Beat carries the module holding the end-op |
| ld_addr | input | ADDR_W | Memory address of the beat's module |
| ld_data | input | MOD_W | Module payload |
| rq_valid | input | 1 | Lookup request present |
| rq_kind | input | 2 | 0 start, 1 step, 2 jump |
| rq_addr | input | ADDR_W | Address for start and jump lookups |
| rq_blk | input | BLK_W | Current block for step lookups |
| rs_valid | output | 1 | Answer present |
| rs_hit | output | 1 | Module is resident |
| rs_miss | output | 1 | Module must come from main memory |
| rs_done | output | 1 | Sequence reached its end-op |
| rs_blk | output | BLK_W | Block index of a hit |
| rs_last | output | 1 | Hit block holds the end-op |
| rs_data | output | MOD_W | Payload of the hit block |

## Verification
The assertions check the answer protocol on every cycle. They cover the one-cycle latency, that exactly one outcome is raised, that the payload fields are zero unless there is a hit, and that a step hit always lands on the block after the requested one, with no step past the last block when wrap is off. Only the bench scenarios can show the placement rules. These are the hashed start block, a start tag destroyed by an overlapping later load, the drop of modules that do not fit, the shifted start block after a failed load, the lowest-index choice among duplicate jump tags, and the different outcomes with wrap on and off. The bench drives the same traffic into one instance with wrap off and one with wrap on.

// File: rtl/ucs_pkg.sv
`timescale 1ns/1ps
package ucs_pkg;
  typedef enum logic [1:0] {
    RQ_START = 2'd0,
    RQ_NEXT  = 2'd1,
    RQ_JUMP  = 2'd2
  } ucs_rq_e;
endpackage

// File: rtl/ucs_res_table.sv
`timescale 1ns/1ps
module ucs_res_table #(
  parameter int NUM_BLK  = 16,
  parameter int NUM_ENT  = 8,
  parameter int FAIL_W   = 4,
  parameter int FAIL_INC = 2,
  localparam int BLK_W = $clog2(NUM_BLK),
  localparam int ENT_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENT_W-1:0] lk_ent,
  output logic             lk_valid,
  output logic [BLK_W-1:0] lk_blk,
  input  logic [ENT_W-1:0] ld_ent,
  output logic [BLK_W-1:0] ld_start,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             fail_en,
  input  logic [ENT_W-1:0] fail_ent
);
  localparam int SHIFT = BLK_W - ENT_W;
  localparam int SW    = (FAIL_W > BLK_W) ? FAIL_W : BLK_W;
  localparam int FMAX  = (1 << FAIL_W) - 1;

  logic [NUM_ENT-1:0] val_q;
  logic [BLK_W-1:0]   blk_q  [NUM_ENT];
  logic [FAIL_W-1:0]  fail_q [NUM_ENT];

  logic [BLK_W-1:0] base;
  logic [SW-1:0]    sum;

  always_comb begin
    base     = BLK_W'(ld_ent) << SHIFT;
    sum      = SW'(base) + SW'(fail_q[ld_ent]);
    ld_start = sum[BLK_W-1:0];
  end

  assign lk_valid = val_q[lk_ent];
  assign lk_blk   = blk_q[lk_ent];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        blk_q[i]  <= '0;
        fail_q[i] <= '0;
      end
    end else begin
      if (set_en) begin
        val_q[ld_ent] <= 1'b1;
        blk_q[ld_ent] <= set_blk;
      end
      if (fail_en) begin
        if (int'(fail_q[fail_ent]) > FMAX - FAIL_INC)
          fail_q[fail_ent] <= FAIL_W'(FMAX);
        else
          fail_q[fail_ent] <= fail_q[fail_ent] + FAIL_W'(FAIL_INC);
      end
    end
  end
endmodule

// File: rtl/ucs_block_meta.sv
`timescale 1ns/1ps
module ucs_block_meta #(
  parameter int NUM_BLK = 16,
  parameter int ADDR_W  = 16,
  localparam int BLK_W = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [BLK_W-1:0]   wr_idx,
  input  logic               wr_first,
  input  logic               wr_end,
  input  logic [ADDR_W-1:0]  wr_tag,
  input  logic [BLK_W-1:0]   rd_idx,
  output logic [ADDR_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0]  cmp_addr,
  output logic [NUM_BLK-1:0] match_v,
  output logic [NUM_BLK-1:0] valid_v,
  output logic [NUM_BLK-1:0] first_v,
  output logic [NUM_BLK-1:0] end_v
);
  logic [ADDR_W-1:0] tag_q [NUM_BLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
      first_v <= '0;
      end_v   <= '0;
    end else if (wr_en) begin
      valid_v[wr_idx] <= 1'b1;
      first_v[wr_idx] <= wr_first;
      end_v[wr_idx]   <= wr_end;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag = tag_q[rd_idx];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_cmp
    assign match_v[g] = valid_v[g] && (tag_q[g] == cmp_addr);
  end
endmodule

// File: rtl/ucs_payload_ram.sv
`timescale 1ns/1ps
module ucs_payload_ram #(
  parameter int NUM_BLK = 16,
  parameter int MOD_W   = 32,
  localparam int BLK_W = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_addr,
  input  logic [MOD_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_addr,
  output logic [MOD_W-1:0] rd_data
);
  logic [MOD_W-1:0] mem [NUM_BLK];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ucs_straight_loader.sv
`timescale 1ns/1ps
module ucs_straight_loader #(
  parameter int NUM_BLK  = 16,
  parameter int NUM_ENT  = 8,
  parameter int ADDR_W   = 16,
  parameter int MOD_W    = 32,
  parameter int FAIL_W   = 4,
  parameter int FAIL_INC = 2,
  parameter bit WRAP_EN  = 1'b0,
  localparam int BLK_W = $clog2(NUM_BLK),
  localparam int ENT_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic              ld_first,
  input  logic              ld_last,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [MOD_W-1:0]  ld_data,
  input  logic              rq_valid,
  input  logic [1:0]        rq_kind,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [BLK_W-1:0]  rq_blk,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic              rs_done,
  output logic [BLK_W-1:0]  rs_blk,
  output logic              rs_last,
  output logic [MOD_W-1:0]  rs_data
);
  import ucs_pkg::*;

  localparam int CNT_W = BLK_W + 1;
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLK - 1);

  // ---------------- load side ----------------
  logic             ld_act_q, ld_room_q, ld_failed_q;
  logic [BLK_W-1:0] ld_ptr_q;
  logic [CNT_W-1:0] ld_cnt_q;
  logic [ENT_W-1:0] ld_ent_q;

  logic [ENT_W-1:0] ld_ent;
  logic [BLK_W-1:0] start_blk;
  logic             beat_first, beat_cont, beat_drop;
  logic             wr_en;
  logic [BLK_W-1:0] wr_idx;

  assign ld_ent     = ld_addr[ENT_W-1:0];
  assign beat_first = ld_valid && ld_first;
  assign beat_cont  = ld_valid && !ld_first && ld_act_q;
  assign beat_drop  = beat_cont && !ld_room_q;
  assign wr_en      = beat_first || (beat_cont && ld_room_q);
  assign wr_idx     = beat_first ? start_blk : ld_ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_act_q    <= 1'b0;
      ld_room_q   <= 1'b0;
      ld_failed_q <= 1'b0;
      ld_ptr_q    <= '0;
      ld_cnt_q    <= '0;
      ld_ent_q    <= '0;
    end else if (beat_first) begin
      ld_act_q    <= !ld_last;
      ld_failed_q <= 1'b0;
      ld_ent_q    <= ld_ent;
      ld_ptr_q    <= start_blk + 1'b1;
      ld_cnt_q    <= CNT_W'(1);
      ld_room_q   <= WRAP_EN ? (NUM_BLK > 1) : (start_blk != LAST_BLK);
    end else if (beat_cont) begin
      if (ld_last) ld_act_q <= 1'b0;
      if (ld_room_q) begin
        ld_ptr_q  <= ld_ptr_q + 1'b1;
        ld_cnt_q  <= ld_cnt_q + 1'b1;
        ld_room_q <= WRAP_EN ? (int'(ld_cnt_q) + 1 < NUM_BLK) : (ld_ptr_q != LAST_BLK);
      end else begin
        ld_failed_q <= 1'b1;
      end
    end
  end

  // ---------------- lookup side ----------------
  ucs_rq_e          kind;
  logic             lk_valid;
  logic [BLK_W-1:0] lk_blk;
  logic [ADDR_W-1:0] lk_tag;
  logic [NUM_BLK-1:0] match_v, valid_v, first_v, end_v;

  assign kind = ucs_rq_e'(rq_kind);

  ucs_res_table #(
    .NUM_BLK(NUM_BLK), .NUM_ENT(NUM_ENT), .FAIL_W(FAIL_W), .FAIL_INC(FAIL_INC)
  ) res_i (
    .clk(clk), .rst(rst),
    .lk_ent(rq_addr[ENT_W-1:0]), .lk_valid(lk_valid), .lk_blk(lk_blk),
    .ld_ent(ld_ent), .ld_start(start_blk),
    .set_en(beat_first), .set_blk(start_blk),
    .fail_en(beat_drop && !ld_failed_q), .fail_ent(ld_ent_q)
  );

  ucs_block_meta #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) meta_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_first(beat_first), .wr_end(ld_last),
    .wr_tag(ld_addr),
    .rd_idx(lk_blk), .rd_tag(lk_tag),
    .cmp_addr(rq_addr), .match_v(match_v),
    .valid_v(valid_v), .first_v(first_v), .end_v(end_v)
  );

  // lowest-index tag match
  logic             jm_any;
  logic [BLK_W-1:0] jm_idx;
  always_comb begin
    jm_any = |match_v;
    jm_idx = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--) begin
      if (match_v[i]) jm_idx = BLK_W'(i);
    end
  end

  logic             o_hit, o_miss, o_done;
  logic [BLK_W-1:0] o_idx, nxt_idx;
  logic             nxt_past;

  assign nxt_idx  = rq_blk + 1'b1;
  assign nxt_past = (rq_blk == LAST_BLK) && !WRAP_EN;

  always_comb begin
    o_hit  = 1'b0;
    o_miss = 1'b0;
    o_done = 1'b0;
    o_idx  = '0;
    unique case (kind)
      RQ_START: begin
        if (lk_valid && valid_v[lk_blk] && first_v[lk_blk] && (lk_tag == rq_addr)) begin
          o_hit = 1'b1;
          o_idx = lk_blk;
        end else begin
          o_miss = 1'b1;
        end
      end
      RQ_NEXT: begin
        if (end_v[rq_blk]) begin
          o_done = 1'b1;
        end else if (!nxt_past && valid_v[nxt_idx] && !first_v[nxt_idx]) begin
          o_hit = 1'b1;
          o_idx = nxt_idx;
        end else begin
          o_miss = 1'b1;
        end
      end
      RQ_JUMP: begin
        o_hit  = jm_any;
        o_miss = !jm_any;
        o_idx  = jm_idx;
      end
      default: o_miss = 1'b1;
    endcase
  end

  logic [MOD_W-1:0] ram_q;

  ucs_payload_ram #(.NUM_BLK(NUM_BLK), .MOD_W(MOD_W)) ram_i (
    .clk(clk),
    .wr_en(wr_en), .wr_addr(wr_idx), .wr_data(ld_data),
    .rd_en(rq_valid), .rd_addr(o_idx), .rd_data(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_done  <= 1'b0;
      rs_blk   <= '0;
      rs_last  <= 1'b0;
    end else begin
      rs_valid <= rq_valid;
      rs_hit   <= rq_valid && o_hit;
      rs_miss  <= rq_valid && o_miss;
      rs_done  <= rq_valid && o_done;
      rs_blk   <= (rq_valid && o_hit) ? o_idx : '0;
      rs_last  <= rq_valid && o_hit && end_v[o_idx];
    end
  end

  assign rs_data = rs_hit ? ram_q : '0;
endmodule

// File: rtl/ucs_straight_loader_chk.sv
`timescale 1ns/1ps
module ucs_straight_loader_chk #(
  parameter int NUM_BLK = 16,
  parameter int MOD_W   = 32,
  parameter bit WRAP_EN = 1'b0,
  localparam int BLK_W = $clog2(NUM_BLK)
) (
  input logic             clk,
  input logic             rst,
  input logic             rq_valid,
  input logic [1:0]       rq_kind,
  input logic [BLK_W-1:0] rq_blk,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_miss,
  input logic             rs_done,
  input logic [BLK_W-1:0] rs_blk,
  input logic             rs_last,
  input logic [MOD_W-1:0] rs_data
);
  import ucs_pkg::*;

  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rs_valid == $past(rq_valid))); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> ($countones({rs_hit, rs_miss, rs_done}) == 1)); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |-> !(rs_hit || rs_miss || rs_done)); // R10

  AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rs_hit |-> (rs_blk == '0 && !rs_last && rs_data == '0)); // R10

  AST_STEP_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rs_hit && $past(rq_kind) == RQ_NEXT)
      |-> (rs_blk == BLK_W'($past(rq_blk) + 1'b1))); // R5

  AST_STEP_NO_PAST_END: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !WRAP_EN && rs_valid && $past(rq_kind) == RQ_NEXT
      && $past(rq_blk) == BLK_W'(NUM_BLK - 1)) |-> !rs_hit); // R3
endmodule

bind ucs_straight_loader ucs_straight_loader_chk #(
  .NUM_BLK(NUM_BLK), .MOD_W(MOD_W), .WRAP_EN(WRAP_EN)
) chk_i (
  .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_kind(rq_kind), .rq_blk(rq_blk),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_done(rs_done),
  .rs_blk(rs_blk), .rs_last(rs_last), .rs_data(rs_data)
);

// File: tb/ucs_straight_loader_tb_top.sv
`timescale 1ns/1ps
module ucs_straight_loader_tb_top;
  import ucs_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        ld_valid, ld_first, ld_last;
  logic [15:0] ld_addr;
  logic [31:0] ld_data;
  logic        rq_valid;
  logic [1:0]  rq_kind;
  logic [15:0] rq_addr;
  logic [3:0]  rq_blk;

  logic        m_v, m_h, m_m, m_d, m_l;
  logic [3:0]  m_b;
  logic [31:0] m_dt;
  logic        w_v, w_h, w_m, w_d, w_l;
  logic [3:0]  w_b;
  logic [31:0] w_dt;

  ucs_straight_loader #(.WRAP_EN(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_first(ld_first), .ld_last(ld_last),
    .ld_addr(ld_addr), .ld_data(ld_data), .rq_valid(rq_valid), .rq_kind(rq_kind),
    .rq_addr(rq_addr), .rq_blk(rq_blk), .rs_valid(m_v), .rs_hit(m_h), .rs_miss(m_m),
    .rs_done(m_d), .rs_blk(m_b), .rs_last(m_l), .rs_data(m_dt));

  ucs_straight_loader #(.WRAP_EN(1'b1)) dut_w (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_first(ld_first), .ld_last(ld_last),
    .ld_addr(ld_addr), .ld_data(ld_data), .rq_valid(rq_valid), .rq_kind(rq_kind),
    .rq_addr(rq_addr), .rq_blk(rq_blk), .rs_valid(w_v), .rs_hit(w_h), .rs_miss(w_m),
    .rs_done(w_d), .rs_blk(w_b), .rs_last(w_l), .rs_data(w_dt));

  typedef struct {
    bit          hit, miss, done, last;
    int          blk;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t qm[$];
  exp_t qw[$];
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [31:0] dat(logic [15:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  function automatic exp_t eh(int b, logic [15:0] a, bit l, string t);
    exp_t x;
    x.hit = 1; x.miss = 0; x.done = 0; x.last = l; x.blk = b; x.data = dat(a); x.tag = t;
    return x;
  endfunction

  function automatic exp_t emiss(string t);
    exp_t x;
    x.hit = 0; x.miss = 1; x.done = 0; x.last = 0; x.blk = 0; x.data = '0; x.tag = t;
    return x;
  endfunction

  function automatic exp_t edone(string t);
    exp_t x;
    x.hit = 0; x.miss = 0; x.done = 1; x.last = 0; x.blk = 0; x.data = '0; x.tag = t;
    return x;
  endfunction

  task automatic cmp(input bit v, h, mi, d, l, input logic [3:0] b, input logic [31:0] dt,
                     ref exp_t q[$], input string nm);
    exp_t x;
    if (!v) return;
    n_chk++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL R10 %s: unexpected answer hit=%0b miss=%0b done=%0b, expected none", nm, h, mi, d);
      return;
    end
    x = q.pop_front();
    if (h !== x.hit || mi !== x.miss || d !== x.done || l !== x.last ||
        int'(b) != x.blk || dt !== x.data) begin
      n_fail++;
      $display("FAIL %s %s: got hit=%0b miss=%0b done=%0b blk=%0d last=%0b data=%h, expected hit=%0b miss=%0b done=%0b blk=%0d last=%0b data=%h",
               x.tag, nm, h, mi, d, b, l, dt, x.hit, x.miss, x.done, x.blk, x.last, x.data);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      cmp(m_v, m_h, m_m, m_d, m_l, m_b, m_dt, qm, "nowrap");
      cmp(w_v, w_h, w_m, w_d, w_l, w_b, w_dt, qw, "wrap");
    end
  end

  // driver
  task automatic ask(input ucs_rq_e k, input logic [15:0] a, input int b,
                     input exp_t xm, input exp_t xw);
    @(negedge clk);
    rq_valid = 1'b1; rq_kind = k; rq_addr = a; rq_blk = 4'(b);
    qm.push_back(xm);
    qw.push_back(xw);
    @(negedge clk);
    rq_valid = 1'b0;
  endtask

  task automatic ld(input logic [15:0] a, input bit f, input bit l);
    @(negedge clk);
    ld_valid = 1'b1; ld_first = f; ld_last = l; ld_addr = a; ld_data = dat(a);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    ld_valid = 0; ld_first = 0; ld_last = 0; ld_addr = '0; ld_data = '0;
    rq_valid = 0; rq_kind = '0; rq_addr = '0; rq_blk = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (m_v || m_h || m_m || m_d || w_v || w_h || w_m || w_d) begin
      n_fail++;
      $display("FAIL R11 reset: got answer flags %0b%0b%0b%0b/%0b%0b%0b%0b, expected all 0",
               m_v, m_h, m_m, m_d, w_v, w_h, w_m, w_d);
    end
    ask(RQ_START, 16'h0101, 0, emiss("R11 empty store"), emiss("R11 empty store"));

    // program A: entry 1 -> blocks 2,3,4
    ld(16'h0101, 1, 0); ld(16'h0110, 0, 0); ld(16'h0120, 0, 1);
    ask(RQ_START, 16'h0101, 0, eh(2, 16'h0101, 0, "R1 start A"), eh(2, 16'h0101, 0, "R1 start A"));
    ask(RQ_NEXT, 16'h0, 2, eh(3, 16'h0110, 0, "R2 step A"), eh(3, 16'h0110, 0, "R2 step A"));
    ask(RQ_NEXT, 16'h0, 3, eh(4, 16'h0120, 1, "R5 step A"), eh(4, 16'h0120, 1, "R5 step A"));
    ask(RQ_NEXT, 16'h0, 4, edone("R6 end-op"), edone("R6 end-op"));
    ask(RQ_JUMP, 16'h0120, 0, eh(4, 16'h0120, 1, "R7 jump hit"), eh(4, 16'h0120, 1, "R7 jump hit"));
    ask(RQ_JUMP, 16'h0999, 0, emiss("R7 jump miss"), emiss("R7 jump miss"));
    ask(RQ_START, 16'h0110, 0, emiss("R4 empty entry"), emiss("R4 empty entry"));

    // B: entry 3 -> block 6; C: entry 2 -> blocks 4,5 (overlaps A)
    ld(16'h0203, 1, 1);
    ld(16'h0302, 1, 0); ld(16'h0330, 0, 1);
    ask(RQ_NEXT, 16'h0, 3, emiss("R5 start-bit stop"), emiss("R5 start-bit stop"));
    ask(RQ_START, 16'h0302, 0, eh(4, 16'h0302, 0, "R2 start C"), eh(4, 16'h0302, 0, "R2 start C"));
    ask(RQ_NEXT, 16'h0, 4, eh(5, 16'h0330, 1, "R5 step C"), eh(5, 16'h0330, 1, "R5 step C"));
    ask(RQ_NEXT, 16'h0, 5, edone("R6 end C"), edone("R6 end C"));

    // D: entry 3 again -> block 6, overwrites B
    ld(16'h0403, 1, 1);
    ask(RQ_START, 16'h0203, 0, emiss("R4 overwritten"), emiss("R4 overwritten"));
    ask(RQ_START, 16'h0403, 0, eh(6, 16'h0403, 1, "R4 start D"), eh(6, 16'h0403, 1, "R4 start D"));

    // E: entry 7 -> block 14, four modules
    ld(16'h0507, 1, 0); ld(16'h0510, 0, 0); ld(16'h0511, 0, 0); ld(16'h0512, 0, 1);
    ask(RQ_START, 16'h0507, 0, eh(14, 16'h0507, 0, "R1 start E"), eh(14, 16'h0507, 0, "R1 start E"));
    ask(RQ_NEXT, 16'h0, 14, eh(15, 16'h0510, 0, "R2 step E"), eh(15, 16'h0510, 0, "R2 step E"));
    ask(RQ_NEXT, 16'h0, 15, emiss("R3 past end"), eh(0, 16'h0511, 0, "R9 step wraps"));
    ask(RQ_JUMP, 16'h0511, 0, emiss("R3 dropped module"), eh(0, 16'h0511, 0, "R9 load wraps"));

    // reload E: offset now 2 without wrap -> block 0
    ld(16'h0507, 1, 0); ld(16'h0510, 0, 0); ld(16'h0511, 0, 0); ld(16'h0512, 0, 1);
    ask(RQ_START, 16'h0507, 0, eh(0, 16'h0507, 0, "R8 shifted start"), eh(14, 16'h0507, 0, "R9 no failure"));
    ask(RQ_START, 16'h0101, 0, emiss("R4 A overwritten"), eh(2, 16'h0101, 0, "R9 A intact"));
    ask(RQ_JUMP, 16'h0512, 0, eh(3, 16'h0512, 1, "R8 full reload"), eh(1, 16'h0512, 1, "R9 wrapped end"));
    ask(RQ_JUMP, 16'h0507, 0, eh(0, 16'h0507, 0, "R7 lowest match"), eh(14, 16'h0507, 0, "R7 single match"));

    repeat (3) @(negedge clk);
    n_chk++;
    if (qm.size() != 0 || qw.size() != 0) begin
      n_fail++;
      $display("FAIL R10 pending: got %0d/%0d unanswered, expected 0/0", qm.size(), qw.size());
    end
    summary();
    $finish;
  end
endmodule